// File: doc/BRIEF.md
# Scanline Counter and Vertical Interrupt Timer

This block keeps the vertical position of a 256-line bitmap display that runs at 60 frames per second. A divider counts enabled system clocks. Each time it has seen a set number of them, one scanline has passed and an 8-bit line counter moves on by one. The counter runs from 0 to 255 and then starts again at 0. The processor reads the line number through a readback port that always shows the two lowest bits as zero.

The same counter also drives two timing signals for the control inputs of an I/O adapter. The mid-frame toggle follows bit 5 of the line number. It is taken again only on lines that are a multiple of 16, so it changes level once every 32 lines. The end-of-area flag is the AND of line bits 7 to 4. It rises when line 240 begins and stays high until the counter wraps to 0. Whether either signal raises a processor interrupt is decided by the adapter's own enable bits, which are not part of this block.

The clock-enable input `tick_en` lets the system clock run faster than the video timebase. A clock on which `tick_en` is low is not counted.

Top module: `vid_scan_timer`

## Requirements
- R1: While `rst_n` is low, and for the two clocks of the synchronous release that follow, the line counter is 0, `vcount_rd` reads 0 and `mid_toggle` and `end_area` are low.
- R2: The line counter advances by exactly one after `CLKS_PER_LINE` clocks on which `tick_en` was high. Clocks with `tick_en` low are not counted.
- R3: The line counter wraps from 255 to 0. With `tick_en` held high, one full frame takes 256 × `CLKS_PER_LINE` clocks.
- R4: `vcount_rd` equals the current line number with bits 1:0 forced to 0.
- R5: `mid_toggle` equals bit 5 of the current line number. It is updated only when a line whose bits 3:0 are zero begins, so it changes level every 32 lines.
- R6: `end_area` is high for lines 240 through 255 and low for lines 0 through 239.
- R7: While `tick_en` stays low, the line counter, `vcount_rd`, `mid_toggle` and `end_area` all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| tick_en | input | 1 | Clock enable for the line timebase |
| vcount_rd | output | 8 | Line number as read by the CPU, with bits 1:0 zero |
| mid_toggle | output | 1 | Periodic timing signal, equal to line bit 5 |
| end_area | output | 1 | High from line 240 to line 255 |

## Verification
All three outputs come from registers that load on the same clock edge: the edge on which the divider completes a line. A result is therefore due one edge after the last enabled clock of a line. The release of reset adds two more edges, which come from the reset synchroniser. The reference model in the bench advances on each rising edge, holds itself in reset for those two synchroniser edges, and is compared with the outputs at the following falling edge. This way every comparison sees the values settled after the edge it models. The frame length is measured in clocks between two rising edges of `end_area` while `tick_en` is held high.

// File: rtl/vst_pkg.sv
package vst_pkg;
  localparam int LINE_W     = 8;
  localparam int TOG_BIT    = 5;
  localparam int SAMPLE_LSB = 4;
  localparam int END_LSB    = 4;
  localparam int RD_MASK_W  = 2;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/line_divider.sv
module line_divider #(
  parameter int CLKS_PER_LINE = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_en,
  output logic line_step
);
  localparam int DW = (CLKS_PER_LINE > 1) ? $clog2(CLKS_PER_LINE) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLKS_PER_LINE - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    div_d     = div_q;
    line_step = 1'b0;
    if (tick_en) begin
      if (div_q == LAST) begin
        div_d     = '0;
        line_step = 1'b1;
      end else begin
        div_d = div_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    div_q <= LAST);

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_en |=> $stable(div_q));
endmodule

// File: rtl/line_counter.sv
module line_counter
  import vst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  line_step,
  output line_t line_q,
  output line_t line_d
);
  always_comb begin
    line_d = line_q;
    if (line_step) line_d = line_q + LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (line_step && line_q == '1) |=> line_q == '0);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    line_step |=> line_q == LINE_W'($past(line_q) + LINE_W'(1)));

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !line_step |=> $stable(line_q));
endmodule

// File: rtl/vtiming_flags.sv
module vtiming_flags
  import vst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  line_step,
  input  line_t line_d,
  input  line_t line_q,
  output logic  tog_q,
  output logic  eoa_q
);
  logic tog_d, eoa_d, sample_line;

  assign sample_line = (line_d[SAMPLE_LSB-1:0] == '0);

  always_comb begin
    tog_d = tog_q;
    eoa_d = eoa_q;
    if (line_step) begin
      if (sample_line) tog_d = line_d[TOG_BIT];
      eoa_d = &line_d[LINE_W-1:END_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      eoa_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      eoa_q <= eoa_d;
    end
  end

  // R5
  tog_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tog_q == line_q[TOG_BIT]);

  // R6
  eoa_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    eoa_q == (line_q >= LINE_W'(240)));

  // R6
  eoa_fall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(eoa_q) |-> line_q == '0);
endmodule

// File: rtl/vid_scan_timer.sv
module vid_scan_timer
  import vst_pkg::*;
#(
  parameter int CLKS_PER_LINE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [LINE_W-1:0] vcount_rd,
  output logic              mid_toggle,
  output logic              end_area
);
  logic  rst_meta, rst_ni;
  logic  line_step;
  line_t line_q, line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  line_divider #(.CLKS_PER_LINE(CLKS_PER_LINE)) i_div (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .tick_en   (tick_en),
    .line_step (line_step)
  );

  line_counter i_cnt (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .line_step (line_step),
    .line_q    (line_q),
    .line_d    (line_d)
  );

  vtiming_flags i_flags (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .line_step (line_step),
    .line_d    (line_d),
    .line_q    (line_q),
    .tog_q     (mid_toggle),
    .eoa_q     (end_area)
  );

  assign vcount_rd = {line_q[LINE_W-1:RD_MASK_W], {RD_MASK_W{1'b0}}};

  // R4
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    vcount_rd[RD_MASK_W-1:0] == '0);
endmodule

// File: tb/test_vid_scan_timer.sv
module test_vid_scan_timer;
  localparam int CPL = 16;
  localparam int FRAME = 256 * CPL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] vcount_rd;
  logic       mid_toggle, end_area;

  vid_scan_timer #(.CLKS_PER_LINE(CPL)) i_vid_scan_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .vcount_rd(vcount_rd), .mid_toggle(mid_toggle), .end_area(end_area)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int m_div = 0, m_line = 0, m_sc = 0, m_prev_line = 0;
  bit m_tog = 0, m_eoa = 0, m_in_rst = 1;
  int cyc = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    m_prev_line = m_line;
    if (!rst_n || m_sc < 2) begin
      if (!rst_n) m_sc = 0; else m_sc++;
      m_in_rst = 1;
      m_div = 0; m_line = 0; m_tog = 0; m_eoa = 0;
    end else begin
      m_in_rst = 0;
      if (tick_en) begin
        if (m_div == CPL - 1) begin
          m_div = 0;
          m_line = (m_line + 1) % 256;
          if (m_line % 16 == 0) m_tog = ((m_line / 32) % 2) == 1;
          m_eoa = (m_line >= 240);
        end else m_div++;
      end
    end
  end

  // per-cycle compare away from the active edge
  bit        meas_on = 0;
  bit        prev_eoa = 0;
  int        rise_cyc = -1;
  int        frame_checks = 0;
  always @(negedge clk) begin
    if (m_in_rst) begin
      check("R1 vcount_rd in reset", vcount_rd, 0);
      check("R1 mid_toggle in reset", mid_toggle, 0);
      check("R1 end_area in reset", end_area, 0);
    end else begin
      check("R2/R4 vcount_rd", vcount_rd, m_line & 8'hFC);
      check("R5 mid_toggle", mid_toggle, m_tog);
      check("R6 end_area", end_area, m_eoa);
      if (m_prev_line == 255 && m_line == 0)
        check("R3 wrap to zero", vcount_rd, 0);
      if (m_line == 240 && m_prev_line == 239)
        check("R6 end_area rise at 240", end_area, 1);
    end
    if (meas_on && end_area && !prev_eoa) begin
      if (rise_cyc >= 0) begin
        check("R3 frame length", cyc - rise_cyc, FRAME);
        frame_checks++;
      end
      rise_cyc = cyc;
    end
    prev_eoa = end_area;
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] held_v;
    logic       held_t, held_e;
    wait_neg(4);
    rst_n = 1'b1;
    // phase 1: continuous enable, three frames, frame length measured
    tick_en = 1'b1;
    meas_on = 1'b1;
    wait_neg(3 * FRAME + 100);
    meas_on = 1'b0;
    check("R3 frame measurements taken", frame_checks >= 2, 1);
    // phase 2: irregular enable
    for (int i = 0; i < FRAME + FRAME / 2; i++) begin
      tick_en = ($urandom % 10) < 7;
      @(negedge clk);
    end
    // phase 3: enable held low, outputs must freeze
    tick_en = 1'b0;
    wait_neg(2);
    held_v = vcount_rd; held_t = mid_toggle; held_e = end_area;
    wait_neg(200);
    check("R7 vcount_rd held", vcount_rd, held_v);
    check("R7 mid_toggle held", mid_toggle, held_t);
    check("R7 end_area held", end_area, held_e);
    // phase 4: run into the end area, then reset in the middle
    tick_en = 1'b1;
    wait_neg(245 * CPL);
    rst_n = 1'b0;
    wait_neg(3);
    check("R1 vcount_rd after mid-run reset", vcount_rd, 0);
    check("R1 end_area after mid-run reset", end_area, 0);
    rst_n = 1'b1;
    wait_neg(40 * CPL);
    tick_en = 1'b0;
    wait_neg(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_neg(100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule